// File: doc/BRIEF.md
# Page Write Engine with Lockable Identification Page

This block sits behind a serial-interface front end that has already decoded an instruction and its address. It collects the data bytes of a write into a page-sized staging buffer, and it decides only at the moment chip select is released whether the write goes ahead. A write goes ahead only if the transfer ended on a byte boundary, at least one data byte arrived, the write-enable latch is set and the target is not protected. If it does, the engine raises its write-in-progress flag for a programmable number of clock cycles. At the end of that time it commits every staged byte into a behavioural array of 64-byte pages in one step.

Next to the main array it keeps one extra 64-byte identification page. This page can be written like an ordinary page until a lock command retires it to read-only state. The lock cannot be undone short of a power-on reset, and the lock state is always visible on an output. A combinational read port returns the byte at any array or identification address. After reset every byte reads 0xFF.

The front end signals a decoded command with `cmd_valid_i`, `cmd_kind_i` and `cmd_addr_i`. It then sends one `data_valid_i` pulse per complete data byte and ends with a `sel_end_i` pulse when chip select rises. At that pulse, `aligned_i` reports whether the bit count was a whole number of bytes.

Top module: `pw_engine`

## Requirements
- R1: After reset `wip_o` and `lock_o` are 0 and every array and identification byte reads 0xFF.
- R2: A write cycle starts only on a `sel_end_i` pulse with `aligned_i` = 1 and at least one data byte received since the command. A partial final byte or an empty transfer starts no cycle and changes no byte.
- R3: An accepted write holds `wip_o` at 1 for exactly WR_CYCLES cycles, starting the cycle after `sel_end_i`. The new data is readable in the first cycle where `wip_o` is 0 again.
- R4: Data bytes go to consecutive offsets from the command address, all within one page. After offset 63 the next byte goes to offset 0 of the same page, and a later byte at the same offset replaces an earlier one. Offsets that received no byte keep their old value.
- R5: Address bits above the array size are ignored, both for writes (`cmd_addr_i`) and for reads (`rd_addr_i`).
- R6: No write and no lock is accepted unless `wel_i` is 1 at the `sel_end_i` pulse.
- R7: `bp_i` protects array pages. The encodings are 00 none, 01 the upper quarter of the pages, 10 the upper half and 11 all pages. A write to a protected page is dropped without a cycle, and the identification page is never affected by `bp_i`.
- R8: A command, data or `sel_end_i` arriving while `wip_o` is 1 is ignored. It starts no later cycle and changes no byte.
- R9: `cmd_kind_i` = 2'b01 writes the identification page with the same offset and wrap rules as R4. It is read with `rd_id_i` = 1, using the low six bits of `rd_addr_i`. Kind 2'b00 targets the array, and kind 2'b11 is never accepted.
- R10: `cmd_kind_i` = 2'b10 with at least one data byte and `wel_i` = 1 runs a write cycle that sets `lock_o` when it ends. `lock_o` then stays 1 until reset, and any later identification page write or lock is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also restores the delivered state |
| cmd_valid_i | input | 1 | Pulse: instruction and address decoded |
| cmd_kind_i | input | 2 | 00 array write, 01 identification write, 10 lock |
| cmd_addr_i | input | ADDR_W | Byte address of the command |
| data_valid_i | input | 1 | Pulse: one complete data byte |
| data_i | input | 8 | Data byte |
| sel_end_i | input | 1 | Pulse: chip select released |
| aligned_i | input | 1 | Transfer ended on a byte boundary (valid with `sel_end_i`) |
| wel_i | input | 1 | Write-enable latch state |
| bp_i | input | 2 | Block-protect field |
| rd_addr_i | input | ADDR_W | Read address |
| rd_id_i | input | 1 | Read from identification page instead of array |
| rd_data_o | output | 8 | Byte at the read address |
| wip_o | output | 1 | Write cycle in progress |
| lock_o | output | 1 | Identification page is locked |

## Verification
On every cycle, the assertions check the following:
- a write cycle begins only right after a chip-select release that was byte-aligned and had the write-enable latch set;
- each cycle lasts exactly WR_CYCLES;
- the lock rises only as a cycle finishes and never falls.

Where the bytes land can only be shown by the bench's scenarios, which compare the read port against a reference model. These scenarios cover in-page wrap and overwrite, the ignored upper address bits, the four protection ranges, commands dropped during a busy cycle, and identification page writes before and after locking.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [1:0] {
        KIND_ARRAY  = 2'b00,
        KIND_IDPAGE = 2'b01,
        KIND_LOCK   = 2'b10
    } wr_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_LOAD = 2'b01,
        ST_BUSY = 2'b10
    } eng_st_e;

endpackage

// File: rtl/pw_cycle_timer.sv
module pw_cycle_timer #(
    parameter int WR_CYCLES = 20,
    localparam int TMR_W = $clog2(WR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic zero_o
);
    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = TMR_W'(WR_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pw_page_buffer.sv
module pw_page_buffer #(
    parameter int PAGE_BYTES = 64,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    wr_i,
    input  logic [OFF_W-1:0]        off_i,
    input  logic [7:0]              data_i,
    output logic [PAGE_BYTES*8-1:0] data_o,
    output logic [PAGE_BYTES-1:0]   mask_o
);
    logic [7:0]            byte_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (clear_i)   mask_d = '0;
        else if (wr_i) mask_d[off_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    always_ff @(posedge clk) begin
        if (wr_i && !clear_i) byte_q[off_i] <= data_i;
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
        assign data_o[g*8 +: 8] = byte_q[g];
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/pw_page_store.sv
module pw_page_store
    import pw_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int PAGE_COUNT = 32,
    localparam int OFF_W  = $clog2(PAGE_BYTES),
    localparam int PG_W   = $clog2(PAGE_COUNT),
    localparam int MEM_AW = OFF_W + PG_W,
    localparam int DEPTH  = PAGE_BYTES * PAGE_COUNT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic [1:0]              kind_i,
    input  logic [PG_W-1:0]         page_i,
    input  logic [PAGE_BYTES*8-1:0] data_i,
    input  logic [PAGE_BYTES-1:0]   mask_i,
    input  logic [MEM_AW-1:0]       rd_addr_i,
    input  logic                    rd_id_i,
    output logic [7:0]              rd_data_o,
    output logic                    lock_o
);
    logic [7:0] mem_q [DEPTH];
    logic [7:0] id_q  [PAGE_BYTES];
    logic       lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (commit_i && kind_i == KIND_LOCK) lock_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (commit_i && kind_i == KIND_ARRAY) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (mask_i[i]) mem_q[{page_i, OFF_W'(i)}] <= data_i[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) id_q[i] <= 8'hFF;
        end else if (commit_i && kind_i == KIND_IDPAGE) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (mask_i[i]) id_q[i] <= data_i[i*8 +: 8];
            end
        end
    end

    assign rd_data_o = rd_id_i ? id_q[rd_addr_i[OFF_W-1:0]] : mem_q[rd_addr_i];
    assign lock_o    = lock_q;
endmodule

// File: rtl/pw_engine.sv
module pw_engine
    import pw_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int PAGE_COUNT = 32,
    parameter int ADDR_W     = 16,
    parameter int WR_CYCLES  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_kind_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic              data_valid_i,
    input  logic [7:0]        data_i,
    input  logic              sel_end_i,
    input  logic              aligned_i,
    input  logic              wel_i,
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              rd_id_i,
    output logic [7:0]        rd_data_o,
    output logic              wip_o,
    output logic              lock_o
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PG_W   = $clog2(PAGE_COUNT);
    localparam int MEM_AW = OFF_W + PG_W;

    typedef struct packed {
        eng_st_e          st;
        logic [1:0]       kind;
        logic [PG_W-1:0]  page;
        logic [OFF_W-1:0] off;
        logic             got;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                    buf_clr, buf_wr, tmr_load, tmr_zero, commit;
    logic                    prot, target_ok, accept;
    logic [PAGE_BYTES*8-1:0] buf_data;
    logic [PAGE_BYTES-1:0]   buf_mask;
    logic                    unused_hi_bits;

    assign unused_hi_bits = ^{cmd_addr_i[ADDR_W-1:MEM_AW], rd_addr_i[ADDR_W-1:MEM_AW]};

    always_comb begin
        case (bp_i)
            2'b01:   prot = &ctl_q.page[PG_W-1:PG_W-2];
            2'b10:   prot = ctl_q.page[PG_W-1];
            2'b11:   prot = 1'b1;
            default: prot = 1'b0;
        endcase
        case (ctl_q.kind)
            KIND_ARRAY:  target_ok = !prot;
            KIND_IDPAGE: target_ok = !lock_o;
            KIND_LOCK:   target_ok = !lock_o;
            default:     target_ok = 1'b0;
        endcase
        accept = aligned_i && ctl_q.got && wel_i && target_ok;
    end

    always_comb begin
        ctl_d    = ctl_q;
        buf_clr  = 1'b0;
        buf_wr   = 1'b0;
        tmr_load = 1'b0;
        commit   = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_valid_i) begin
                    ctl_d.st   = ST_LOAD;
                    ctl_d.kind = cmd_kind_i;
                    ctl_d.page = cmd_addr_i[MEM_AW-1:OFF_W];
                    ctl_d.off  = cmd_addr_i[OFF_W-1:0];
                    ctl_d.got  = 1'b0;
                    buf_clr    = 1'b1;
                end
            end
            ST_LOAD: begin
                if (data_valid_i) begin
                    buf_wr    = 1'b1;
                    ctl_d.off = ctl_q.off + 1'b1;
                    ctl_d.got = 1'b1;
                end
                if (sel_end_i) begin
                    tmr_load = accept;
                    ctl_d.st = accept ? ST_BUSY : ST_IDLE;
                end
            end
            ST_BUSY: begin
                if (tmr_zero) begin
                    commit   = 1'b1;
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, kind: 2'b00, page: '0, off: '0, got: 1'b0};
        else        ctl_q <= ctl_d;
    end

    pw_cycle_timer #(.WR_CYCLES(WR_CYCLES)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .zero_o (tmr_zero)
    );

    pw_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) i_buffer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (buf_clr),
        .wr_i    (buf_wr),
        .off_i   (ctl_q.off),
        .data_i  (data_i),
        .data_o  (buf_data),
        .mask_o  (buf_mask)
    );

    pw_page_store #(.PAGE_BYTES(PAGE_BYTES), .PAGE_COUNT(PAGE_COUNT)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .kind_i    (ctl_q.kind),
        .page_i    (ctl_q.page),
        .data_i    (buf_data),
        .mask_i    (buf_mask),
        .rd_addr_i (rd_addr_i[MEM_AW-1:0]),
        .rd_id_i   (rd_id_i),
        .rd_data_o (rd_data_o),
        .lock_o    (lock_o)
    );

    assign wip_o = (ctl_q.st == ST_BUSY);
endmodule

// File: rtl/pw_engine_chk.sv
module pw_engine_chk #(
    parameter int WR_CYCLES = 20
) (
    input logic clk,
    input logic rst_n,
    input logic sel_end_i,
    input logic aligned_i,
    input logic wel_i,
    input logic wip_o,
    input logic lock_o
);
    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_q <= 0;
        else if (wip_o) run_q <= run_q + 1;
        else            run_q <= 0;
    end

    assert_start_on_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip_o) |-> $past(sel_end_i));

    assert_start_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip_o) |-> $past(aligned_i));

    assert_start_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip_o) |-> $past(wel_i));

    assert_cycle_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip_o) |-> run_q == WR_CYCLES);

    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o);

    assert_lock_at_cycle_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $fell(wip_o));
endmodule

bind pw_engine pw_engine_chk #(.WR_CYCLES(WR_CYCLES)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_end_i (sel_end_i),
    .aligned_i (aligned_i),
    .wel_i     (wel_i),
    .wip_o     (wip_o),
    .lock_o    (lock_o)
);

// File: tb/test_pw_engine.sv
`timescale 1ns/1ps
module test_pw_engine;
    localparam int W     = 12;
    localparam int DEPTH = 2048;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_valid = 0, data_valid = 0, sel_end = 0, aligned = 0, wel = 0, rd_id = 0;
    logic [1:0]  cmd_kind = 0, bp = 0;
    logic [15:0] cmd_addr = 0, rd_addr = 0;
    logic [7:0]  data = 0, rd_data;
    logic        wip, lock;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pw_engine #(.PAGE_BYTES(64), .PAGE_COUNT(32), .ADDR_W(16), .WR_CYCLES(W)) i_pw_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_kind_i(cmd_kind),
        .cmd_addr_i(cmd_addr), .data_valid_i(data_valid), .data_i(data),
        .sel_end_i(sel_end), .aligned_i(aligned), .wel_i(wel), .bp_i(bp),
        .rd_addr_i(rd_addr), .rd_id_i(rd_id), .rd_data_o(rd_data),
        .wip_o(wip), .lock_o(lock)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_mem [DEPTH];
    logic [7:0] m_id  [64];
    bit         m_lock, m_coll;
    int         m_busy, m_kind, m_addr;
    logic [7:0] m_q [$];

    function automatic bit m_prot(int page);
        case (bp)
            2'b01:   return page >= 24;
            2'b10:   return page >= 16;
            2'b11:   return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit m_accept();
        bit ok;
        if (!aligned || m_q.size() == 0 || !wel) return 0;
        case (m_kind)
            0:       ok = !m_prot((m_addr % DEPTH) / 64);
            1, 2:    ok = !m_lock;
            default: ok = 0;
        endcase
        return ok;
    endfunction

    task automatic m_apply();
        for (int i = 0; i < m_q.size(); i++) begin
            int off = (m_addr % 64 + i) % 64;
            if (m_kind == 0)      m_mem[((m_addr % DEPTH) / 64) * 64 + off] = m_q[i];
            else if (m_kind == 1) m_id[off] = m_q[i];
        end
        if (m_kind == 2) m_lock = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            foreach (m_id[i])  m_id[i]  = 8'hFF;
            m_lock = 0; m_busy = 0; m_coll = 0; m_q.delete();
        end else if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) m_apply();
        end else if (!m_coll) begin
            if (cmd_valid) begin
                m_coll = 1; m_kind = cmd_kind; m_addr = cmd_addr; m_q.delete();
            end
        end else begin
            if (data_valid) m_q.push_back(data);
            if (sel_end) begin
                m_coll = 0;
                if (m_accept()) m_busy = W;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 model wip", wip, m_busy > 0);
            check("R10 model lock", lock, m_lock);
            check("R4/R9 model read", rd_data,
                  rd_id ? m_id[rd_addr % 64] : m_mem[rd_addr % DEPTH]);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [7:0] pat(int seed, int i);
        return 8'((seed + i * 13) & 255);
    endfunction

    task automatic send(int kind, int addr, int n, int seed, bit whole);
        @(posedge clk); #1;
        cmd_valid = 1; cmd_kind = 2'(kind); cmd_addr = 16'(addr);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            cmd_valid = 0; data_valid = 1; data = pat(seed, i);
        end
        @(posedge clk); #1;
        cmd_valid = 0; data_valid = 0; sel_end = 1; aligned = whole;
        @(posedge clk); #1;
        sel_end = 0; aligned = 0;
    endtask

    task automatic run(string tag, int kind, int addr, int n, int seed, bit whole, bit exp_start);
        int cnt = 0;
        send(kind, addr, n, seed, whole);
        @(negedge clk);
        check({tag, " start"}, wip, exp_start);
        while (wip) begin
            cnt++;
            @(negedge clk);
        end
        if (exp_start) check("R3 cycle length", cnt, W);
    endtask

    task automatic rd_chk(string tag, bit id, int addr, int exp);
        @(posedge clk); #1;
        rd_id = id; rd_addr = 16'(addr);
        @(negedge clk);
        check(tag, rd_data, exp);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 delivered state
        check("R1 wip", wip, 0);
        check("R1 lock", lock, 0);
        rd_chk("R1 array byte", 0, 100, 8'hFF);
        rd_chk("R1 id byte", 1, 7, 8'hFF);

        wel = 1;
        // R3 single byte, visible when wip falls
        run("R3 byte write", 0, 16'h0105, 1, 8'h5A, 1, 1);
        rd_chk("R3 byte data", 0, 16'h0105, pat(8'h5A, 0));
        rd_chk("R4 neighbour untouched", 0, 16'h0106, 8'hFF);

        // R4 full page and wrap with overwrite
        run("R4 page write", 0, 3 * 64, 64, 8'h11, 1, 1);
        rd_chk("R4 first byte", 0, 3 * 64, pat(8'h11, 0));
        rd_chk("R4 last byte", 0, 3 * 64 + 63, pat(8'h11, 63));
        run("R4 wrap write", 0, 5 * 64 + 62, 66, 8'h20, 1, 1);
        rd_chk("R4 overwrite offset 62", 0, 5 * 64 + 62, pat(8'h20, 64));
        rd_chk("R4 wrapped offset 0", 0, 5 * 64, pat(8'h20, 2));
        rd_chk("R4 next page untouched", 0, 6 * 64, 8'hFF);

        // R2 partial byte and empty transfer
        run("R2 partial byte", 0, 16'h0200, 3, 8'h33, 0, 0);
        rd_chk("R2 partial unchanged", 0, 16'h0200, 8'hFF);
        run("R2 no data", 0, 16'h0201, 0, 8'h00, 1, 0);

        // R5 high address bits ignored
        run("R5 high write", 0, 16'hF805, 1, 8'h77, 1, 1);
        rd_chk("R5 low alias read", 0, 16'h0005, pat(8'h77, 0));
        rd_chk("R5 high alias read", 0, 16'hA005, pat(8'h77, 0));

        // R6 write enable latch
        wel = 0;
        run("R6 no wel", 0, 16'h0300, 1, 8'h44, 1, 0);
        rd_chk("R6 unchanged", 0, 16'h0300, 8'hFF);
        wel = 1;

        // R7 protection ranges
        bp = 2'b01;
        run("R7 quarter blocked", 0, 24 * 64, 1, 8'h01, 1, 0);
        run("R7 quarter open", 0, 23 * 64, 1, 8'h02, 1, 1);
        bp = 2'b10;
        run("R7 half blocked", 0, 16 * 64, 1, 8'h03, 1, 0);
        run("R7 half open", 0, 15 * 64, 1, 8'h04, 1, 1);
        bp = 2'b11;
        run("R7 all blocked", 0, 0, 1, 8'h05, 1, 0);
        rd_chk("R7 page 0 unchanged", 0, 0, 8'hFF);
        run("R7 id page unaffected", 1, 10, 2, 8'h66, 1, 1);
        rd_chk("R9 id data", 1, 11, pat(8'h66, 1));
        bp = 2'b00;

        // R8 command during busy ignored
        send(0, 16'h0400, 1, 8'h88, 1);
        send(0, 16'h0440, 2, 8'h99, 1);
        @(negedge clk);
        while (wip) @(negedge clk);
        @(negedge clk);
        check("R8 no second cycle", wip, 0);
        rd_chk("R8 dropped data", 0, 16'h0440, 8'hFF);
        rd_chk("R8 first data", 0, 16'h0400, pat(8'h88, 0));

        // R9 kind 2'b11 never accepted
        run("R9 bad kind", 3, 16'h0500, 1, 8'h12, 1, 0);

        // R10 lock
        wel = 0;
        run("R10 lock without wel", 2, 0, 1, 8'h00, 1, 0);
        check("R10 still unlocked", lock, 0);
        wel = 1;
        run("R10 lock no data", 2, 0, 0, 8'h00, 1, 0);
        run("R10 lock", 2, 0, 1, 8'h00, 1, 1);
        check("R10 locked", lock, 1);
        run("R10 id write after lock", 1, 11, 1, 8'hC3, 1, 0);
        rd_chk("R10 id kept", 1, 11, pat(8'h66, 1));
        run("R10 array still writable", 0, 16'h0600, 1, 8'h3C, 1, 1);
        check("R10 lock persists", lock, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule